// File: doc/BRIEF.md
# I2C Master Clock Generator

This block makes the serial clock for an I2C controller while the controller is a master, either sending or receiving. It drives SCL through an open-drain style pull-low enable. It also reads back the real line level, so that a slave stretching the clock or another master's clock on the same wired-AND line shapes the waveform. When master operation is off, the generator lets go of the line and stays quiet.

A two-bit select sets the rate. Two codes divide the system clock by a fixed ratio, and a speed input halves both ratios. The other two codes take their time base from an external timer overflow strobe, so that one SCL period spans eight strobes. Each time the block starts pulling SCL low, it pulses a fall strobe for one cycle. Each time it first sees the released line high, it pulses a rise strobe for one cycle. The data shifter uses these two strobes.

Top module: `scl_gen`

## Requirements
- R1: While `master_en` is 0, `scl_pull` is 0 and neither strobe pulses. Dropping `master_en` releases the line on the following cycle.
- R2: With `dbl_speed`=0 and `rate_sel`=0, one SCL period is 120 system clocks: 60 cycles pulled low and 60 cycles released.
- R3: With `dbl_speed`=0 and `rate_sel`=1, one period is 9600 clocks, split 4800 low and 4800 released.
- R4: With `dbl_speed`=1, both fixed ratios are halved. `rate_sel`=0 gives 30 low and 30 released. `rate_sel`=1 gives 2400 low and 2400 released.
- R5: With `rate_sel`=2 or 3, the low phase lasts four `tmr_ovf` strobes and the counted high phase lasts four strobes sampled with SCL high. For example, with one strobe every 10 clocks, the steady state is 40 low and 40 released.
- R6: The high-phase count does not begin until `scl_in` is sampled high. While SCL is held low externally, the block waits. It emits `scl_rise` one cycle after the line is freed.
- R7: If `scl_in` is sampled low during a high phase that has already been counting, the block pulls SCL low at that edge, with `scl_fall`, and restarts a full low phase.
- R8: `scl_fall` is a one-cycle pulse in the first cycle of every pulled-low phase, and `scl_pull` never rises without it.
- R9: `scl_rise` is a one-cycle pulse in the first cycle in which the released line is seen high, and never while the block is pulling. In a free-running phase it comes H-1 cycles before the next `scl_fall`, where H is the half period.
- R10: After `master_en` is raised, the generator starts with a released (high) phase. The first strobe is `scl_rise`, which appears two cycles after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master transmit/receive active |
| rate_sel | input | 2 | 0: short fixed ratio, 1: long fixed ratio, 2/3: timer based |
| dbl_speed | input | 1 | Halves the fixed ratios |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-cycle strobe at an SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe at an SCL falling edge |

## Verification
The main function is run in four timing patterns. The two fixed ratios are each run at normal and doubled speed, which separates wrong divisors and wrong halving. The timer-based select is driven by a regular strobe, which separates counting strobes from counting clocks. A free-running bus shows the 50% duty cycle. Holding the line low past the end of the low phase shows stretching. Pulling it low in the middle of a counted high phase shows the restart behaviour. A disable interval and a fresh enable show the release behaviour and the start-high ordering.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } scl_state_e;

  localparam logic [1:0] RATE_NEAR = 2'd0;
  localparam logic [1:0] RATE_FAR  = 2'd1;
endpackage

// File: rtl/scl_rate_sel.sv
module scl_rate_sel #(
  parameter int DIV_NEAR  = 120,
  parameter int DIV_FAR   = 9600,
  parameter int TMR_STEPS = 8,
  parameter int CNT_W     = 13
) (
  input  logic [1:0]       rate_sel,
  input  logic             dbl_speed,
  input  logic             tmr_ovf,
  output logic             tick,
  output logic [CNT_W-1:0] half_len
);
  import scl_gen_pkg::*;

  localparam int NEAR_STD = DIV_NEAR / 2;
  localparam int NEAR_DBL = DIV_NEAR / 4;
  localparam int FAR_STD  = DIV_FAR / 2;
  localparam int FAR_DBL  = DIV_FAR / 4;
  localparam int TMR_HALF = TMR_STEPS / 2;

  always_comb begin
    tick     = 1'b1;
    half_len = CNT_W'(NEAR_STD);
    unique case (rate_sel)
      RATE_NEAR: half_len = dbl_speed ? CNT_W'(NEAR_DBL) : CNT_W'(NEAR_STD);
      RATE_FAR:  half_len = dbl_speed ? CNT_W'(FAR_DBL)  : CNT_W'(FAR_STD);
      default: begin
        tick     = tmr_ovf;
        half_len = CNT_W'(TMR_HALF);
      end
    endcase
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] half_len,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, half_len};

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || adv) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int DIV_NEAR  = 120,
  parameter int DIV_FAR   = 9600,
  parameter int TMR_STEPS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic [1:0] rate_sel,
  input  logic       dbl_speed,
  input  logic       tmr_ovf,
  input  logic       scl_in,
  output logic       scl_pull,
  output logic       scl_rise,
  output logic       scl_fall
);
  import scl_gen_pkg::*;

  localparam int CNT_W = $clog2(DIV_FAR / 2 + 1);

  scl_state_e       state_q, state_d;
  logic             seen_q, seen_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             tick, last, adv, clr;
  logic [CNT_W-1:0] half_len;

  scl_rate_sel #(
    .DIV_NEAR (DIV_NEAR),
    .DIV_FAR  (DIV_FAR),
    .TMR_STEPS(TMR_STEPS),
    .CNT_W    (CNT_W)
  ) u_rate (
    .rate_sel (rate_sel),
    .dbl_speed(dbl_speed),
    .tmr_ovf  (tmr_ovf),
    .tick     (tick),
    .half_len (half_len)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .adv     (adv),
    .half_len(half_len),
    .last    (last)
  );

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    adv     = 1'b0;
    clr     = 1'b0;
    if (!master_en) begin
      state_d = ST_IDLE;
      seen_d  = 1'b0;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_HIGH;
          seen_d  = 1'b0;
          clr     = 1'b1;
        end
        ST_LOW: begin
          adv = tick;
          if (tick && last) begin
            state_d = ST_HIGH;
            seen_d  = 1'b0;
            clr     = 1'b1;
          end
        end
        ST_HIGH: begin
          if (seen_q && !scl_in) begin
            // another clock source pulled the line: restart low phase
            state_d = ST_LOW;
            fall_d  = 1'b1;
            clr     = 1'b1;
          end else if (scl_in) begin
            adv    = tick;
            seen_d = 1'b1;
            rise_d = !seen_q;
            if (tick && last) begin
              state_d = ST_LOW;
              fall_d  = 1'b1;
              clr     = 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          clr     = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign scl_pull = (state_q == ST_LOW);
  assign scl_rise = rise_q;
  assign scl_fall = fall_q;
endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic scl_pull,
  input logic scl_rise,
  input logic scl_fall
);
  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!scl_pull && !scl_rise && !scl_fall));

  p_fall_starts_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> scl_fall);

  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall);

  p_rise_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> !scl_pull);

  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));
endmodule

bind scl_gen scl_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .master_en(master_en),
  .scl_pull (scl_pull),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall)
);

// File: tb/sim_scl_gen.sv
module sim_scl_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       dbl_speed = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       ext_hold = 1'b0;
  logic       tmr_run = 1'b0;
  logic       scl_in;
  logic       scl_pull, scl_rise, scl_fall;
  int         n_chk = 0;
  int         n_err = 0;
  localparam int LIMIT = 20000;

  always #4 clk = ~clk;

  assign scl_in = ~(scl_pull | ext_hold);

  scl_gen u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .rate_sel(rate_sel),
    .dbl_speed(dbl_speed), .tmr_ovf(tmr_ovf), .scl_in(scl_in),
    .scl_pull(scl_pull), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  initial begin : tmr_gen
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      if (tmr_run) begin
        div = (div == 9) ? 0 : div + 1;
        tmr_ovf = (div == 9);
      end else begin
        div = 0;
        tmr_ovf = 1'b0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    int n;
    n = 0;
    while (!scl_fall && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rise();
    int n;
    n = 0;
    while (!scl_rise && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic count_pull(input logic want, output int n);
    n = 0;
    while (scl_pull == want && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic restart(input logic [1:0] sel, input logic dbl);
    @(negedge clk);
    master_en = 1'b0;
    repeat (3) @(negedge clk);
    rate_sel  = sel;
    dbl_speed = dbl;
    master_en = 1'b1;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1 reset pull", scl_pull, 0);
    check("R1 reset strobes", scl_rise | scl_fall, 0);
    rst_n = 1'b1;
  endtask

  // free-running measurement: enable, first rise, rise-to-fall, low, high
  task automatic t_fixed(input string req, input logic [1:0] sel, input logic dbl,
                         input int h);
    int n;
    restart(sel, dbl);
    n = 0;
    while (!scl_rise && n < 10) begin n++; @(negedge clk); end
    check({req, " R10 first rise delay"}, n, 2);
    check({req, " R10 no fall before rise"}, scl_pull, 0);
    n = 0;
    while (!scl_fall && n < LIMIT) begin n++; @(negedge clk); end
    check({req, " R9 rise to fall"}, n, h - 1);
    check({req, " R8 fall with pull"}, scl_pull, 1);
    count_pull(1'b1, n);
    check({req, " low phase"}, n, h);
    count_pull(1'b0, n);
    check({req, " high phase"}, n, h);
  endtask

  task automatic t_timer(input logic [1:0] sel);
    int n;
    tmr_run = 1'b1;
    restart(sel, 1'b0);
    wait_fall();
    @(negedge clk);
    wait_fall();
    count_pull(1'b1, n);
    check("R5 timer low", n, 40);
    count_pull(1'b0, n);
    check("R5 timer high", n, 40);
    tmr_run = 1'b0;
  endtask

  task automatic t_stretch();
    int n;
    restart(2'd0, 1'b0);
    wait_fall();
    ext_hold = 1'b1;
    repeat (200) @(negedge clk);
    check("R6 released while held", scl_pull, 0);
    check("R6 no rise while held", scl_rise, 0);
    ext_hold = 1'b0;
    @(negedge clk);
    check("R6 rise after release", scl_rise, 1);
    n = 0;
    while (!scl_fall && n < LIMIT) begin n++; @(negedge clk); end
    check("R6 high counted after release", n, 59);
  endtask

  task automatic t_sync();
    int n;
    restart(2'd0, 1'b0);
    wait_rise();
    repeat (10) @(negedge clk);
    ext_hold = 1'b1;
    @(negedge clk);
    check("R7 sync fall strobe", scl_fall, 1);
    check("R7 sync pull", scl_pull, 1);
    ext_hold = 1'b0;
    count_pull(1'b1, n);
    check("R7 full low after sync", n, 60);
  endtask

  task automatic t_disable();
    int seen;
    restart(2'd0, 1'b0);
    wait_fall();
    @(negedge clk);
    master_en = 1'b0;
    @(negedge clk);
    check("R1 release on disable", scl_pull, 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (scl_pull || scl_rise || scl_fall) seen++;
      @(negedge clk);
    end
    check("R1 quiet while disabled", seen, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed("R2", 2'd0, 1'b0, 60);
    t_fixed("R4 near", 2'd0, 1'b1, 30);
    t_fixed("R3", 2'd1, 1'b0, 4800);
    t_fixed("R4 far", 2'd1, 1'b1, 2400);
    t_timer(2'd2);
    t_timer(2'd3);
    t_stretch();
    t_sync();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule